// File: doc/BRIEF.md
# SD Command and Response Engine

This block drives one command transaction on the command line of an SD or MMC card and, when asked, captures the card's reply. A controller presents an 8-bit command field (the low six bits are the command index), a 32-bit argument and five control flags, then pulses `start`. The engine assembles the 48-bit command token, computes its CRC7, and shifts it out most significant bit first, one bit per card clock. Each cycle of `clk` is one card clock; `card_clk_en` tells the clock gate when the card clock must run.

When a reply is requested, the engine releases the line and watches for the card's start bit within a fixed window. It then shifts in a 48-bit or a 136-bit frame, checks it, and places the payload in four 32-bit result registers. Completion is signalled by a one-cycle `done` pulse, with `resp_timeout` and `resp_err` held until the next transaction starts. An optional tail of eight card clocks can follow the transaction.

Top module: `sd_cmd_engine`

## Requirements
- R1: The token is sent MSB first over 48 consecutive card clocks with `cmd_oe` high: bit 47 = 0, bit 46 = 1, bits 45:40 = command index, bits 39:8 = argument, bits 7:1 = CRC7 (polynomial x^7+x^3+1, zero seed) over bits 47:8, bit 0 = 1. `cmd_oe` is high for no other cycle.
- R2: Bits 7:6 of `cmd_word` have no effect on the token; the index is `cmd_word[5:0]`.
- R3: With `get_resp` low, the engine takes no reply: `done` follows the token (plus any tail) after exactly 48 card clocks, with both status flags low.
- R4: With `add_tail` high, exactly 8 more card clocks run after the transaction (after the token, the timeout or the last reply bit) before `done`.
- R5: A reply start bit (0 on `cmd_in`) is accepted in any of the 64 card clocks after the token's end bit; if none arrives, `resp_timeout` is set and no reply is taken. `resp_timeout` and `resp_err` are never both set.
- R6: For a short reply (48 bits, frame bit 47 first), `resp0` = frame bits 39:8 and `resp1`..`resp3` are zero.
- R7: For a long reply (136 bits), `resp0` = frame bits 31:0, `resp1` = 63:32, `resp2` = 95:64, `resp3` = 127:96; no CRC is checked.
- R8: A short reply whose bits 7:1 differ from the CRC7 of its bits 47:8 sets `resp_err`, unless `skip_crc` is high.
- R9: A reply of either length whose last bit is 0 sets `resp_err`, whatever `skip_crc` is.
- R10: After reset: `busy`, `done`, `cmd_oe`, both flags and all result registers are 0 and `cmd_out` is 1. `busy` is high from the cycle after `start` until `done`, `done` is a one-cycle pulse, and both flags clear when a new transaction starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (sampled while idle) |
| cmd_word | input | 8 | Command field; bits 5:0 are the index |
| arg | input | 32 | Command argument |
| get_resp | input | 1 | Expect a reply |
| long_resp | input | 1 | Reply is 136 bits instead of 48 |
| skip_crc | input | 1 | Do not flag CRC mismatch on a short reply |
| add_tail | input | 1 | Run eight extra card clocks at the end |
| cmd_in | input | 1 | Command line as seen from the card side |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| card_clk_en | output | 1 | Card clock must run this cycle |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| resp_timeout | output | 1 | No reply start bit in the window |
| resp_err | output | 1 | Reply failed its end-bit or CRC check |
| resp0 | output | 32 | Result bits 31:0 |
| resp1 | output | 32 | Result bits 63:32 |
| resp2 | output | 32 | Result bits 95:64 |
| resp3 | output | 32 | Result bits 127:96 |

## Verification
The assertions watch the framing invariants on every cycle: the line is only driven inside a busy transaction with the card clock running, `done` is a single pulse that coincides with the end of `busy`, the two status flags are exclusive, and both are clear when a transaction begins. The content of the token and its CRC, the exact card-clock counts with and without the tail, the 63-versus-64 clock timeout edge, the placement of short and long payloads in the result registers, and the CRC and end-bit error cases depend on what the card sends and are shown only by the bench's scenarios, which play the card's side of the line.

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter int WAIT_CLKS  = 64,
  parameter int TAIL_CLKS  = 8,
  parameter int SHORT_BITS = 48,
  parameter int LONG_BITS  = 136
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  cmd_word,
  input  logic [31:0] arg,
  input  logic        get_resp,
  input  logic        long_resp,
  input  logic        skip_crc,
  input  logic        add_tail,
  input  logic        cmd_in,
  output logic        cmd_out,
  output logic        cmd_oe,
  output logic        card_clk_en,
  output logic        busy,
  output logic        done,
  output logic        resp_timeout,
  output logic        resp_err,
  output logic [31:0] resp0,
  output logic [31:0] resp1,
  output logic [31:0] resp2,
  output logic [31:0] resp3
);
  localparam int TOK_BITS = 48;
  localparam int CNT_W    = $clog2(LONG_BITS + 1);

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_WAIT, S_RECV, S_TAIL} state_t;

  function automatic logic [6:0] crc7_of(input logic [39:0] d);
    logic [6:0] c;
    logic       fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  state_t                 state;
  logic [CNT_W-1:0]       cnt;
  logic [TOK_BITS-1:0]    tx_sr;
  logic [LONG_BITS-1:0]   rx_sr;
  logic                   want_resp, want_long, no_crc, want_tail;

  logic [39:0]            tok_body;
  logic [TOK_BITS-1:0]    tok;
  logic [LONG_BITS-1:0]   rx_next;
  logic [SHORT_BITS-1:0]  short_f;
  logic                   short_bad, long_bad;
  logic [CNT_W-1:0]       rx_last;

  assign tok_body = {2'b01, cmd_word[5:0], arg};
  assign tok      = {tok_body, crc7_of(tok_body), 1'b1};
  assign rx_next  = {rx_sr[LONG_BITS-2:0], cmd_in};
  assign short_f  = rx_next[SHORT_BITS-1:0];
  assign short_bad = !short_f[0] || (!no_crc && (crc7_of(short_f[47:8]) != short_f[7:1]));
  assign long_bad  = !rx_next[0];
  assign rx_last  = want_long ? CNT_W'(LONG_BITS - 1) : CNT_W'(SHORT_BITS - 1);

  assign busy        = (state != S_IDLE);
  assign card_clk_en = busy;
  assign cmd_oe      = (state == S_SEND);
  assign cmd_out     = cmd_oe ? tx_sr[TOK_BITS-1] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      cnt          <= '0;
      tx_sr        <= '0;
      rx_sr        <= '0;
      want_resp    <= 1'b0;
      want_long    <= 1'b0;
      no_crc       <= 1'b0;
      want_tail    <= 1'b0;
      done         <= 1'b0;
      resp_timeout <= 1'b0;
      resp_err     <= 1'b0;
      resp0        <= '0;
      resp1        <= '0;
      resp2        <= '0;
      resp3        <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            tx_sr        <= tok;
            want_resp    <= get_resp;
            want_long    <= long_resp;
            no_crc       <= skip_crc;
            want_tail    <= add_tail;
            resp_timeout <= 1'b0;
            resp_err     <= 1'b0;
            cnt          <= '0;
            state        <= S_SEND;
          end
        end
        S_SEND: begin
          tx_sr <= {tx_sr[TOK_BITS-2:0], 1'b1};
          if (cnt == CNT_W'(TOK_BITS - 1)) begin
            cnt <= '0;
            if (want_resp)      state <= S_WAIT;
            else if (want_tail) state <= S_TAIL;
            else begin
              state <= S_IDLE;
              done  <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (!cmd_in) begin
            rx_sr <= '0;
            cnt   <= CNT_W'(1);
            state <= S_RECV;
          end else if (cnt == CNT_W'(WAIT_CLKS - 1)) begin
            resp_timeout <= 1'b1;
            cnt          <= '0;
            if (want_tail) state <= S_TAIL;
            else begin
              state <= S_IDLE;
              done  <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RECV: begin
          rx_sr <= rx_next;
          if (cnt == rx_last) begin
            if (want_long) begin
              resp0    <= rx_next[31:0];
              resp1    <= rx_next[63:32];
              resp2    <= rx_next[95:64];
              resp3    <= rx_next[127:96];
              resp_err <= long_bad;
            end else begin
              resp0    <= short_f[39:8];
              resp1    <= '0;
              resp2    <= '0;
              resp3    <= '0;
              resp_err <= short_bad;
            end
            cnt <= '0;
            if (want_tail) state <= S_TAIL;
            else begin
              state <= S_IDLE;
              done  <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_TAIL: begin
          if (cnt == CNT_W'(TAIL_CLKS - 1)) begin
            cnt   <= '0;
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [7:0]  cmd_word,
  input logic [31:0] arg,
  input logic        get_resp,
  input logic        long_resp,
  input logic        skip_crc,
  input logic        add_tail,
  input logic        cmd_in,
  input logic        cmd_out,
  input logic        cmd_oe,
  input logic        card_clk_en,
  input logic        busy,
  input logic        done,
  input logic        resp_timeout,
  input logic        resp_err,
  input logic [31:0] resp0,
  input logic [31:0] resp1,
  input logic [31:0] resp2,
  input logic [31:0] resp3
);
  AST_DRIVE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) cmd_oe |-> (busy && card_clk_en)); // R1
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !cmd_oe |-> cmd_out); // R1
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R10
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R10
  AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> (!resp_timeout && !resp_err)); // R10
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(resp_timeout && resp_err)); // R5
endmodule

bind sd_cmd_engine sd_cmd_engine_chk u_chk (.*);

// File: tb/test_sd_cmd_engine.sv
module test_sd_cmd_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] cmd_word = '0;
  logic [31:0] arg = '0;
  logic get_resp = 0, long_resp = 0, skip_crc = 0, add_tail = 0, cmd_in = 1'b1;
  logic cmd_out, cmd_oe, card_clk_en, busy, done, resp_timeout, resp_err;
  logic [31:0] resp0, resp1, resp2, resp3;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_engine i_sd_cmd_engine (.*);

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [135:0] act, input logic [135:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [39:0] m);
    logic [46:0] r;
    r = {m, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'b1000_1001;
    return r[6:0];
  endfunction

  // kind: 0 good reply, 1 bad CRC, 2 bad end bit, 3 card silent
  typedef struct packed {
    logic [7:0]  idx;
    logic [31:0] a;
    logic gr, lg, ig, ap;
    logic [1:0]  kind;
    logic [6:0]  dly;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 7'd0},
    '{8'hC5, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 7'd0},
    '{8'h11, 32'h1234_5678, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 7'd0},
    '{8'h08, 32'h0000_01AA, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 7'd63},
    '{8'h37, 32'h0F0F_0F0F, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 7'd0},
    '{8'h37, 32'hF0F0_F0F0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 7'd0},
    '{8'h02, 32'hCAFE_0001, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 7'd5},
    '{8'h0D, 32'h0001_0000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 7'd3},
    '{8'h0D, 32'h0002_0000, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 7'd3},
    '{8'h07, 32'h8000_0001, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 7'd1},
    '{8'h09, 32'h5555_AAAA, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 7'd0},
    '{8'h0A, 32'h7654_3210, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 7'd2},
    '{8'h03, 32'h0BAD_F00D, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 7'd64}
  };

  task automatic run_vec(input vec_t v, input int k);
    logic [47:0]  exp_tok, tok;
    logic [135:0] frame;
    logic [127:0] lp;
    logic [31:0]  sp;
    int nbits, clks, nlen, wcnt, j, exp_clks;
    bit oe_prev, waiting, fin, exp_to, exp_err;
    nbits = 0; clks = 0; wcnt = 0; j = 0; oe_prev = 0; waiting = 0; fin = 0;
    tok = '0;
    exp_tok = {2'b01, v.idx[5:0], v.a, ref_crc({2'b01, v.idx[5:0], v.a}), 1'b1};
    nlen = v.lg ? 136 : 48;
    sp = v.a ^ 32'hA5A5_A5A5;
    lp = {v.a, ~v.a, v.a ^ 32'h3C3C_C3C3, v.a[31:1], 1'b1};
    frame = '0;
    if (v.lg) frame = {2'b00, 6'h3F, lp};
    else      frame[47:0] = {2'b00, v.idx[5:0], sp, ref_crc({2'b00, v.idx[5:0], sp}), 1'b1};
    if (v.kind == 2'd1) frame[1] = ~frame[1];
    if (v.kind == 2'd2) frame[0] = 1'b0;
    exp_to  = v.gr && (v.kind == 2'd3 || v.dly >= 7'd64);
    exp_err = v.gr && !exp_to && (v.kind == 2'd2 || (v.kind == 2'd1 && !v.lg && !v.ig));
    if (!v.gr)      exp_clks = 48;
    else if (exp_to) exp_clks = 112;
    else             exp_clks = 48 + int'(v.dly) + nlen;
    if (v.ap) exp_clks += 8;

    @(negedge clk);
    cmd_word = v.idx; arg = v.a; get_resp = v.gr; long_resp = v.lg;
    skip_crc = v.ig; add_tail = v.ap; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !resp_timeout && !resp_err, $sformatf("R10 vec%0d busy/flags at start", k),
        {busy, resp_timeout, resp_err}, 3'b100);
    for (int it = 0; it < 400; it++) begin
      if (done) begin fin = 1; break; end
      if (cmd_oe) begin tok = {tok[46:0], cmd_out}; nbits++; end
      if (card_clk_en) clks++;
      if (oe_prev && !cmd_oe) begin waiting = 1; wcnt = 0; end
      if (waiting && v.gr && v.kind != 2'd3) begin
        if (wcnt >= int'(v.dly) && j < nlen) begin cmd_in = frame[nlen-1-j]; j++; end
        else cmd_in = 1'b1;
        wcnt++;
      end
      oe_prev = cmd_oe;
      @(negedge clk);
    end
    cmd_in = 1'b1;
    chk(fin, $sformatf("R10 vec%0d done reached", k), fin, 1);
    chk(nbits == 48 && tok == exp_tok, $sformatf("R1 R2 vec%0d token", k), tok, exp_tok);
    chk(clks == exp_clks, $sformatf("R3 R4 R5 vec%0d card clocks", k), clks, exp_clks);
    chk(resp_timeout == exp_to, $sformatf("R5 vec%0d timeout flag", k), resp_timeout, exp_to);
    chk(resp_err == exp_err, $sformatf("R8 R9 vec%0d error flag", k), resp_err, exp_err);
    if (v.gr && !exp_to) begin
      if (v.lg)
        chk({resp3, resp2, resp1, resp0} == frame[127:0], $sformatf("R7 vec%0d long payload", k),
            {resp3, resp2, resp1, resp0}, frame[127:0]);
      else
        chk({resp3, resp2, resp1, resp0} == {96'h0, frame[39:8]}, $sformatf("R6 vec%0d short payload", k),
            {resp3, resp2, resp1, resp0}, {96'h0, frame[39:8]});
    end
    @(negedge clk);
    chk(!done, $sformatf("R10 vec%0d done single pulse", k), done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !cmd_oe && cmd_out && !resp_timeout && !resp_err, "R10 reset outputs",
        {busy, done, cmd_oe, cmd_out, resp_timeout, resp_err}, 6'b000100);
    chk({resp3, resp2, resp1, resp0} == '0, "R10 reset result registers", {resp3, resp2, resp1, resp0}, 0);
    for (int k = 0; k < NV; k++) run_vec(VECS[k], k);
    // command line held low while idle must not start anything
    cmd_in = 1'b0;
    repeat (5) @(negedge clk);
    chk(!busy && !cmd_oe, "R10 idle ignores line", {busy, cmd_oe}, 0);
    cmd_in = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule